// File: doc/BRIEF.md
# Accumulator CPU Core with Word-Serial Memory Port

This block is a 16-bit accumulator processor with no local storage for code or data. It keeps three architectural registers: an accumulator D, an A register that serves both as a memory pointer and as a loadable constant, and a program counter. A six-bit-controlled ALU combines D with either A or a memory word. Every instruction word, every memory operand and every store crosses a single request/done port, one 16-bit word per transaction, so a serial memory engine can sit behind it.

A control sequencer steps each instruction through fetch, decode, an operand read only when the instruction uses memory, execute, and a store only when the instruction writes memory. Each memory phase waits for the engine's done pulse. An external halt input parks the core between instructions, and the sequencer state is exported for observation.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low and after it rises, PC, A and D are zero and the sequencer is in the fetch state; the first fetch therefore requests address 0.
- R2: The state code on `state_o` is 0 fetch, 1 decode, 2 operand read, 3 execute, 4 store. `mem_req_o` is high in fetch (when not halted), operand read and store, and low otherwise; `mem_we_o` is high only in the store state; in fetch the address is PC.
- R3: An instruction whose bit 15 is 0 loads its bits 14:0, zero-extended, into A, moves PC to PC+1 and causes no operand read and no store.
- R4: An instruction whose bits 15:13 are 111 is a compute instruction; bits 11:6 (from high to low: zero x, invert x, zero y, invert y, add-not-AND, invert result) control the ALU with x = D, giving the 18 standard results (0, 1, -1, x, y, ~x, ~y, -x, -y, x+1, y+1, x-1, y-1, x+y, x-y, y-x, x&y, x|y).
- R5: When bit 12 of a compute instruction is 1, y is the memory word at address A, fetched by one read transaction between decode and execute; when it is 0, y is A and no read occurs.
- R6: Destination bits select the result's targets: bit 5 writes A, bit 4 writes D, bit 3 issues one store transaction of the result.
- R7: A store goes to the value A held before the instruction, even when the same instruction also writes A.
- R8: Jump bits 2, 1, 0 test result < 0, = 0, > 0 respectively; if any selected test holds, PC loads the pre-instruction A, otherwise PC increments. PC changes only in execute.
- R9: While `halt_i` is high and the sequencer is in fetch, no request is issued and the state stays at fetch; the current instruction still completes first.
- R10: Each memory phase holds its state, address and request until `mem_done_i` is sampled high, for any response latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Park the core at the next fetch |
| mem_req_o | output | 1 | Word transaction requested |
| mem_we_o | output | 1 | Transaction is a store |
| mem_addr_o | output | 16 | Word address of the transaction |
| mem_wdata_o | output | 16 | Store data |
| mem_rdata_i | input | 16 | Read data, valid with done |
| mem_done_i | input | 1 | One-cycle pulse ending a transaction |
| state_o | output | 3 | Sequencer state code |

## Verification
Two functions fall in the same execute cycle when one compute instruction both stores to memory and overwrites A: the store address must come from the old A while A takes the new result, and a jump in that cycle must also use the old A. The bench provokes this with a read-modify-write that increments a memory word and simultaneously loads the sum into A, then stores D through the new A; it judges the pair by the logged store addresses and data. It also raises halt while an instruction is in flight and judges that the core finishes that instruction and then parks in fetch with the request low.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int unsigned STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_READ   = 3'd2,
      ST_EXEC   = 3'd3,
      ST_WRITE  = 3'd4
   } cpu_state_e;

   typedef struct packed {
      logic zero_x;
      logic inv_x;
      logic zero_y;
      logic inv_y;
      logic sel_add;
      logic inv_out;
   } alu_ctl_t;

   localparam int unsigned ALU_CTL_W = $bits(alu_ctl_t);

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  alu_ctl_t          ctl_i,
   output logic [DATA_W-1:0] res_o,
   output logic              neg_o,
   output logic              zero_o,
   output logic              pos_o
);

   localparam int unsigned N_OPND = 2;

   logic [N_OPND-1:0][DATA_W-1:0] raw_opnd;
   logic [N_OPND-1:0][DATA_W-1:0] cond_opnd;
   logic [N_OPND-1:0]             clr_bit;
   logic [N_OPND-1:0]             flip_bit;
   logic [DATA_W-1:0]             core_res;

   assign raw_opnd = {y_i, x_i};
   assign clr_bit  = {ctl_i.zero_y, ctl_i.zero_x};
   assign flip_bit = {ctl_i.inv_y, ctl_i.inv_x};

   generate
      for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
         assign cond_opnd[g] = (clr_bit[g] ? '0 : raw_opnd[g]) ^ {DATA_W{flip_bit[g]}};
      end
   endgenerate

   assign core_res = ctl_i.sel_add ? (cond_opnd[0] + cond_opnd[1])
                                   : (cond_opnd[0] & cond_opnd[1]);
   assign res_o    = core_res ^ {DATA_W{ctl_i.inv_out}};
   assign neg_o    = res_o[DATA_W-1];
   assign zero_o   = (res_o == '0);
   assign pos_o    = !neg_o && !zero_o;

   always_comb begin
      assert ($onehot({neg_o, zero_o, pos_o}));  // R8
   end

endmodule

// File: rtl/acc_cpu_jump.sv
module acc_cpu_jump #(
   parameter int unsigned COND_W = 3
) (
   input  logic [COND_W-1:0] sel_i,
   input  logic              neg_i,
   input  logic              zero_i,
   input  logic              pos_i,
   output logic              take_o
);

   logic [COND_W-1:0] hits;

   generate
      if (COND_W != 3) begin : g_bad_cond
         $error("acc_cpu_jump: COND_W must be 3");
      end
   endgenerate

   assign hits   = {neg_i, zero_i, pos_i};
   assign take_o = |(sel_i & hits);

endmodule

// File: rtl/acc_cpu_fsm.sv
module acc_cpu_fsm
   import acc_cpu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_i,
   input  logic       mem_done_i,
   input  logic       is_comp_i,
   input  logic       use_mem_i,
   input  logic       store_i,
   output cpu_state_e state_o,
   output logic       mem_req_o,
   output logic       mem_we_o
);

   cpu_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_FETCH:  if (mem_done_i && !halt_i) state_d = ST_DECODE;
         ST_DECODE: state_d = (is_comp_i && use_mem_i) ? ST_READ : ST_EXEC;
         ST_READ:   if (mem_done_i) state_d = ST_EXEC;
         ST_EXEC:   state_d = (is_comp_i && store_i) ? ST_WRITE : ST_FETCH;
         ST_WRITE:  if (mem_done_i) state_d = ST_FETCH;
         default:   state_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_FETCH;
      else        state_q <= state_d;
   end

   assign state_o   = state_q;
   assign mem_req_o = ((state_q == ST_FETCH) && !halt_i) ||
                      (state_q == ST_READ) || (state_q == ST_WRITE);
   assign mem_we_o  = (state_q == ST_WRITE);

   AST_HOLD_FOR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_READ || state_q == ST_WRITE) && !mem_done_i) |=> $stable(state_q)); // R10
   AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH && !mem_done_i) |=> (state_q == ST_FETCH)); // R10
   AST_HALT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH && halt_i) |=> (state_q == ST_FETCH)); // R9
   AST_DECODE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DECODE) |=> (state_q == ST_READ || state_q == ST_EXEC)); // R5
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITE) |=> (state_q == ST_WRITE || state_q == ST_FETCH)); // R2

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned RESET_PC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_done_i,
   output logic [STATE_W-1:0] state_o
);

   localparam int unsigned OP_BIT   = DATA_W - 1;
   localparam int unsigned IMM_W    = DATA_W - 1;
   localparam int unsigned MSEL_BIT = 12;
   localparam int unsigned CTL_LSB  = 6;
   localparam int unsigned DST_A    = 5;
   localparam int unsigned DST_D    = 4;
   localparam int unsigned DST_M    = 3;
   localparam int unsigned JMP_W    = 3;

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("acc_cpu_core: instruction format needs DATA_W == 16");
      end
      if (RESET_PC >= (1 << DATA_W)) begin : g_bad_pc
         $error("acc_cpu_core: RESET_PC out of range");
      end
   endgenerate

   cpu_state_e        state;
   logic [DATA_W-1:0] pc_q, a_q, d_q, ir_q, opnd_q, waddr_q, wdata_q;
   logic [DATA_W-1:0] y_sel, alu_res;
   logic              alu_neg, alu_zero, alu_pos, jmp_take;
   logic              is_comp;
   alu_ctl_t          alu_ctl;

   assign is_comp = ir_q[OP_BIT];
   assign alu_ctl = alu_ctl_t'(ir_q[CTL_LSB +: ALU_CTL_W]);
   assign y_sel   = ir_q[MSEL_BIT] ? opnd_q : a_q;

   acc_cpu_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_i     (halt_i),
      .mem_done_i (mem_done_i),
      .is_comp_i  (is_comp),
      .use_mem_i  (ir_q[MSEL_BIT]),
      .store_i    (ir_q[DST_M]),
      .state_o    (state),
      .mem_req_o  (mem_req_o),
      .mem_we_o   (mem_we_o)
   );

   acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
      .x_i    (d_q),
      .y_i    (y_sel),
      .ctl_i  (alu_ctl),
      .res_o  (alu_res),
      .neg_o  (alu_neg),
      .zero_o (alu_zero),
      .pos_o  (alu_pos)
   );

   acc_cpu_jump #(.COND_W(JMP_W)) u_jump (
      .sel_i  (ir_q[JMP_W-1:0]),
      .neg_i  (alu_neg),
      .zero_i (alu_zero),
      .pos_i  (alu_pos),
      .take_o (jmp_take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q   <= '0;
         opnd_q <= '0;
      end else begin
         if (state == ST_FETCH && mem_done_i && !halt_i) ir_q <= mem_rdata_i;
         if (state == ST_READ && mem_done_i) opnd_q <= mem_rdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= DATA_W'(RESET_PC);
         a_q     <= '0;
         d_q     <= '0;
         waddr_q <= '0;
         wdata_q <= '0;
      end else if (state == ST_EXEC) begin
         if (!is_comp) begin
            a_q  <= {1'b0, ir_q[IMM_W-1:0]};
            pc_q <= pc_q + 1'b1;
         end else begin
            if (ir_q[DST_A]) a_q <= alu_res;
            if (ir_q[DST_D]) d_q <= alu_res;
            if (ir_q[DST_M]) begin
               waddr_q <= a_q;
               wdata_q <= alu_res;
            end
            pc_q <= jmp_take ? a_q : pc_q + 1'b1;
         end
      end
   end

   always_comb begin
      unique case (state)
         ST_READ:  mem_addr_o = a_q;
         ST_WRITE: mem_addr_o = waddr_q;
         default:  mem_addr_o = pc_q;
      endcase
   end

   assign mem_wdata_o = wdata_q;
   assign state_o     = state;

   AST_IMM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE && !ir_q[OP_BIT]) |=> (state == ST_EXEC)); // R3
   AST_PC_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_EXEC) |=> $stable(pc_q)); // R8
   AST_D_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_EXEC) |=> $stable(d_q)); // R6
   AST_STORE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> mem_req_o); // R6
   AST_STORE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WRITE && !mem_done_i) |=> $stable(mem_addr_o)); // R10

endmodule

// File: tb/test_acc_cpu_core.sv
`timescale 1ns/1ps
module test_acc_cpu_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        halt = 1'b0;
   logic        mem_req, mem_we, mem_done;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic [2:0]  state;

   int checks = 0;
   int failures = 0;

   logic [15:0] mem [0:4095];
   logic [15:0] wlog_a [0:63];
   logic [15:0] wlog_d [0:63];
   int wcount, fetches, reads200, end_hits, viol, lat, mcnt;
   logic [15:0] end_watch;

   always #4 clk = ~clk;

   acc_cpu_core i_acc_cpu_core (
      .clk(clk), .rst_n(rst_n), .halt_i(halt),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_done_i(mem_done),
      .state_o(state)
   );

   // serial memory model: inputs change 2 ns after the rising edge
   initial begin
      mem_done = 1'b0; mem_rdata = '0; mcnt = 0;
      forever begin
         @(posedge clk); #2;
         if (!rst_n || mem_done) begin
            mem_done = 1'b0; mcnt = 0;
         end else if (mem_req) begin
            mcnt++;
            if (mcnt >= lat) begin
               mem_done = 1'b1;
               if (mem_we) begin
                  mem[mem_addr[11:0]] = mem_wdata;
                  if (wcount < 64) begin
                     wlog_a[wcount] = mem_addr; wlog_d[wcount] = mem_wdata;
                  end
                  wcount++;
               end else begin
                  mem_rdata = mem[mem_addr[11:0]];
                  if (state == 3'd0) begin
                     fetches++;
                     if (mem_addr == end_watch) end_hits++;
                  end else if (state == 3'd2 && mem_addr == 16'd200) reads200++;
               end
            end
         end
      end
   end

   // protocol monitor (R2, R10)
   initial begin
      viol = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (((state == 3'd0 && !halt) || state == 3'd2 || state == 3'd4) && !mem_req) viol++;
            if ((state == 3'd1 || state == 3'd3) && mem_req) viol++;
            if (mem_we && state != 3'd4) viol++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ai(input logic [15:0] v);
      return {1'b0, v[14:0]};
   endfunction

   function automatic logic [15:0] ci(input logic a, input logic [5:0] c, input logic [2:0] d, input logic [2:0] j);
      return {3'b111, a, c, d, j};
   endfunction

   function automatic logic [5:0] op_code(input int i);
      case (i)
         0: return 6'b101010;  1: return 6'b111111;  2: return 6'b111010;
         3: return 6'b001100;  4: return 6'b110000;  5: return 6'b001101;
         6: return 6'b110001;  7: return 6'b001111;  8: return 6'b110011;
         9: return 6'b011111; 10: return 6'b110111; 11: return 6'b001110;
        12: return 6'b110010; 13: return 6'b000010; 14: return 6'b010011;
        15: return 6'b000111; 16: return 6'b000000; default: return 6'b010101;
      endcase
   endfunction

   function automatic logic [15:0] op_ref(input int i, input logic [15:0] x, input logic [15:0] y);
      case (i)
         0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
         3: return x;         4: return y;         5: return ~x;
         6: return ~y;        7: return -x;        8: return -y;
         9: return x + 1;    10: return y + 1;    11: return x - 1;
        12: return y - 1;    13: return x + y;    14: return x - y;
        15: return y - x;    16: return x & y;    default: return x | y;
      endcase
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wcount = 0; fetches = 0; reads200 = 0; end_hits = 0; viol = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_to_end(input logic [15:0] e, input string req);
      int n;
      end_watch = e;
      n = 0;
      while (end_hits < 2 && n < 4000) begin
         @(negedge clk); n++;
      end
      check(end_hits >= 2, req, n, 0);
   endtask

   // R1: reset values and first fetch
   task automatic t_reset();
      clear_mem();
      mem[0] = ci(0, 6'b001100, 3'b001, 3'b000);  // M=D at A
      mem[1] = ai(1);
      mem[2] = ci(0, 6'b101010, 3'b000, 3'b111);
      mem[0] = mem[0];
      lat = 3;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check(state == 3'd0, "R1 state in reset", state, 0);
      check(!mem_we, "R1 no store in reset", mem_we, 0);
      rst_n = 1'b1;
      wcount = 0; fetches = 0; end_hits = 0; viol = 0;
      @(negedge clk);
      check(mem_req && mem_addr == 16'd0, "R1 first fetch at 0", {mem_req, mem_addr}, 17'h10000);
      run_to_end(16'd1, "R1 program end");
      check(wcount >= 1 && wlog_a[0] == 16'd0 && wlog_d[0] == 16'd0, "R1 A and D cleared",
            {wlog_a[0], wlog_d[0]}, 0);
   endtask

   // R3 R4 R6: every ALU result through a store
   task automatic t_alu();
      clear_mem();
      mem[0] = ai(16'h1234);
      mem[1] = ci(0, 6'b110000, 3'b010, 3'b000);
      mem[2] = ai(16'h0F0F);
      for (int i = 0; i < 18; i++) mem[3+i] = ci(0, op_code(i), 3'b001, 3'b000);
      mem[21] = ai(21);
      mem[22] = ci(0, 6'b101010, 3'b000, 3'b111);
      lat = 2;
      do_reset();
      run_to_end(16'd21, "R4 alu program end");
      check(wcount == 18, "R6 store count", wcount, 18);
      for (int i = 0; i < 18; i++) begin
         check(wlog_a[i] == 16'h0F0F && wlog_d[i] == op_ref(i, 16'h1234, 16'h0F0F),
               $sformatf("R4 op %0d", i), {wlog_a[i], wlog_d[i]}, {16'h0F0F, op_ref(i, 16'h1234, 16'h0F0F)});
      end
      check(viol == 0, "R2 request framing", viol, 0);
   endtask

   // R5 R7 R10: operand reads and store address under two latencies
   task automatic t_operand(input int l);
      clear_mem();
      mem[200] = 16'h0011;
      mem[0] = ai(200);
      mem[1] = ci(1, 6'b110000, 3'b010, 3'b000);  // D=M
      mem[2] = ci(1, 6'b000010, 3'b010, 3'b000);  // D=D+M
      mem[3] = ci(1, 6'b110111, 3'b101, 3'b000);  // AM=M+1
      mem[4] = ci(0, 6'b001100, 3'b001, 3'b000);  // M=D
      mem[5] = ai(5);
      mem[6] = ci(0, 6'b101010, 3'b000, 3'b111);
      lat = l;
      do_reset();
      run_to_end(16'd5, "R10 operand program end");
      check(reads200 == 3, $sformatf("R5 operand reads lat %0d", l), reads200, 3);
      check(wcount == 2, "R6 two stores", wcount, 2);
      check(wlog_a[0] == 16'd200 && wlog_d[0] == 16'h0012, "R7 store uses old A",
            {wlog_a[0], wlog_d[0]}, {16'd200, 16'h0012});
      check(wlog_a[1] == 16'h0012 && wlog_d[1] == 16'h0022, "R5 D from memory, A updated",
            {wlog_a[1], wlog_d[1]}, {16'h0012, 16'h0022});
      check(viol == 0, "R10 request held through latency", viol, 0);
   endtask

   // R8: all jump conditions on negative, zero, positive results
   task automatic t_jump();
      for (int v = 0; v < 3; v++) begin
         for (int j = 0; j < 8; j++) begin
            logic taken;
            clear_mem();
            mem[0] = ai(16'd5);
            mem[1] = (v == 0) ? ci(0, 6'b110011, 3'b010, 3'b000) :
                     (v == 1) ? ci(0, 6'b101010, 3'b010, 3'b000) :
                                ci(0, 6'b110000, 3'b010, 3'b000);
            mem[2] = ai(16'd10);
            mem[3] = ci(0, 6'b001100, 3'b000, 3'(j));
            mem[4] = ai(16'h300);
            mem[5] = ci(0, 6'b101010, 3'b001, 3'b000);
            mem[6] = ai(16'd20);
            mem[7] = ci(0, 6'b101010, 3'b000, 3'b111);
            mem[10] = ai(16'h300);
            mem[11] = ci(0, 6'b111111, 3'b001, 3'b000);
            mem[12] = ai(16'd20);
            mem[13] = ci(0, 6'b101010, 3'b000, 3'b111);
            mem[20] = ai(16'd20);
            mem[21] = ci(0, 6'b101010, 3'b000, 3'b111);
            lat = 1;
            do_reset();
            run_to_end(16'd20, "R8 jump program end");
            taken = (j[2] && v == 0) || (j[1] && v == 1) || (j[0] && v == 2);
            check(wcount == 1 && wlog_d[0] == {15'd0, taken},
                  $sformatf("R8 cond %0d sign %0d", j, v), wlog_d[0], {15'd0, taken});
         end
      end
   endtask

   // R9 R3: halt from reset and between instructions
   task automatic t_halt();
      int bad, n, f0;
      clear_mem();
      mem[0] = ai(16'h7FFF);
      mem[1] = ci(0, 6'b110000, 3'b010, 3'b000);
      mem[2] = ai(16'h50);
      mem[3] = ci(0, 6'b001100, 3'b001, 3'b000);
      mem[4] = ai(4);
      mem[5] = ci(0, 6'b101010, 3'b000, 3'b111);
      lat = 2;
      halt = 1'b1;
      do_reset();
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (mem_req || state != 3'd0) bad++;
      end
      check(bad == 0 && fetches == 0, "R9 parked from reset", bad + fetches, 0);
      halt = 1'b0;
      n = 0;
      while (wcount < 1 && n < 500) begin @(negedge clk); n++; end
      check(wcount == 1 && wlog_a[0] == 16'h50 && wlog_d[0] == 16'h7FFF, "R3 zero-extended immediate",
            {wlog_a[0], wlog_d[0]}, {16'h50, 16'h7FFF});
      halt = 1'b1;
      n = 0;
      while (!(state == 3'd0 && !mem_req) && n < 100) begin @(negedge clk); n++; end
      f0 = fetches;
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (mem_req || state != 3'd0) bad++;
      end
      check(bad == 0 && fetches == f0, "R9 parked between instructions", bad, 0);
      halt = 1'b0;
      @(negedge clk);
      check(mem_req && state == 3'd0, "R9 resume fetch", {mem_req, state}, 4'b1000);
   endtask

   initial begin
      lat = 1; end_watch = 16'hFFFF;
      wcount = 0; fetches = 0; reads200 = 0; end_hits = 0;
      t_reset();
      t_alu();
      t_operand(1);
      t_operand(7);
      t_jump();
      t_halt();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule